// File: doc/BRIEF.md
# Flowlet Next-Hop Pinning Table

This block picks the next hop for each data packet so that the packets of one flow stay on one path for as long as they arrive close together. A flow hash selects an entry in a small table. Each entry holds the time its flow was last seen and the hop the flow is currently pinned to. When the idle time since that last packet is larger than a threshold set at run time, a new flowlet begins. The block then asks an external best-hop lookup for the packet's destination and pins the flow to the answer.

Packets arrive with a valid strobe, a flow hash, a destination identifier and the current value of a free-running 16-bit time counter. The destination is presented combinationally on a lookup request port, and the best hop is expected back in the same cycle. One cycle later the block reports the chosen hop, plus a flag that shows whether a new flowlet was started. Computing the hash and maintaining the best-hop table are done outside the block.

Top module: `flowlet_pin`

## Requirements
- R1: Out of reset, `out_valid` and `out_new` are 0. A packet accepted in cycle t (`pkt_valid`=1) produces `out_valid`=1 in cycle t+1. When no packet arrived in cycle t, `out_valid` is 0 in cycle t+1.
- R2: When a packet's flowlet has expired, `out_hop` equals the `best_hop` value present in the packet's cycle, `out_new`=1, and the entry is re-pinned to that hop.
- R3: When a packet's flowlet has not expired, `out_hop` equals the hop pinned in its entry, `out_new`=0, and `best_hop` is ignored.
- R4: Every packet stores its arrival time in its entry, whether or not the hop changed. A stream whose spacing never exceeds the threshold therefore stays pinned for any total duration.
- R5: After reset every entry counts as never written. The first packet that hits an entry always counts as expired.
- R6: A flowlet has expired when (`now` − stored time) mod 2^16 is strictly greater than `gap_thresh`. A gap equal to the threshold keeps the pin.
- R7: The gap is computed modulo 2^16, so a time counter that wraps between two packets gives their true distance.
- R8: A packet that hits the same entry in the cycle right after a previous packet sees that packet's updated time and hop.
- R9: `best_dst` always equals `pkt_dst`, which forms the lookup request for the same cycle.
- R10: A packet changes only the entry its hash selects. The pins and times of all other entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is present this cycle |
| pkt_hash | input | IDX_W | Flow hash that selects the table entry |
| pkt_dst | input | DST_W | Destination identifier of the packet |
| now | input | TS_W | Free-running time counter |
| gap_thresh | input | TS_W | Idle gap that must be exceeded to start a new flowlet |
| best_dst | output | DST_W | Destination sent to the best-hop lookup |
| best_hop | input | HOP_W | Best hop returned for `best_dst`, same cycle |
| out_valid | output | 1 | Result for the previous cycle's packet |
| out_new | output | 1 | The result started a new flowlet |
| out_hop | output | HOP_W | Chosen next hop |

## Verification
Two functions can meet in one cycle: writing an entry for one packet and reading the same entry for the next packet. The bench provokes this by sending packets to the same hash in consecutive cycles. It does so once with a gap of one tick, which must keep the hop just written, and once with a large gap, which must re-pin using the updated time. The bench also changes the best-hop answer between the two packets. A read that returned stale state would then show up as a wrong hop or a wrong `out_new` flag, judged against a bench model of the table.

// File: rtl/flowlet_pin.sv
module flowlet_pin #(
  parameter int IDX_W = 4,
  parameter int DST_W = 4,
  parameter int HOP_W = 3,
  parameter int TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [IDX_W-1:0] pkt_hash,
  input  logic [DST_W-1:0] pkt_dst,
  input  logic [TS_W-1:0]  now,
  input  logic [TS_W-1:0]  gap_thresh,
  output logic [DST_W-1:0] best_dst,
  input  logic [HOP_W-1:0] best_hop,
  output logic             out_valid,
  output logic             out_new,
  output logic [HOP_W-1:0] out_hop
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [TS_W-1:0]    ts_q  [ENTRIES];
  logic [HOP_W-1:0]   hop_q [ENTRIES];
  logic [ENTRIES-1:0] seen_q;

  logic [TS_W-1:0]  rd_ts, gap;
  logic [HOP_W-1:0] rd_hop, pick;
  logic             rd_seen, expired;

  assign best_dst = pkt_dst;
  assign rd_ts    = ts_q[pkt_hash];
  assign rd_hop   = hop_q[pkt_hash];
  assign rd_seen  = seen_q[pkt_hash];
  assign gap      = now - rd_ts;
  assign expired  = !rd_seen || (gap > gap_thresh);
  assign pick     = expired ? best_hop : rd_hop;

  always_ff @(posedge clk) begin
    if (pkt_valid) begin
      ts_q[pkt_hash]  <= now;
      hop_q[pkt_hash] <= pick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= '0;
      out_valid <= 1'b0;
      out_new   <= 1'b0;
      out_hop   <= '0;
    end else begin
      out_valid <= pkt_valid;
      out_new   <= pkt_valid && expired;
      if (pkt_valid) begin
        seen_q[pkt_hash] <= 1'b1;
        out_hop          <= pick;
      end
    end
  end
endmodule

module flowlet_pin_chk #(
  parameter int IDX_W = 4,
  parameter int HOP_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pkt_valid,
  input logic [IDX_W-1:0]        pkt_hash,
  input logic [HOP_W-1:0]        best_hop,
  input logic                    out_valid,
  input logic                    out_new,
  input logic [HOP_W-1:0]        out_hop,
  input logic [HOP_W-1:0]        rd_hop,
  input logic [(1<<IDX_W)-1:0]   seen_q
);
  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> out_valid);

  assert_no_spurious_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !out_valid);

  assert_new_takes_best_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && rst_n) ##1 (out_valid && out_new) |-> out_hop == $past(best_hop));

  assert_pinned_keeps_hop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && rst_n) ##1 (out_valid && !out_new) |-> out_hop == $past(rd_hop));

  assert_first_hit_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !seen_q[pkt_hash]) |=> out_new);

  assert_new_implies_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_new |-> out_valid);
endmodule

bind flowlet_pin flowlet_pin_chk #(.IDX_W(IDX_W), .HOP_W(HOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_hash(pkt_hash),
  .best_hop(best_hop), .out_valid(out_valid), .out_new(out_new),
  .out_hop(out_hop), .rd_hop(rd_hop), .seen_q(seen_q)
);

// File: tb/tb_flowlet_pin.sv
module tb_flowlet_pin;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4, DST_W = 4, HOP_W = 3, TS_W = 16;
  localparam int N = 1 << IDX_W;

  logic clk = 0, rst_n = 0, pkt_valid = 0;
  logic [IDX_W-1:0] pkt_hash = '0;
  logic [DST_W-1:0] pkt_dst = '0;
  logic [TS_W-1:0]  now = '0, gap_thresh = '0;
  logic [DST_W-1:0] best_dst;
  logic [HOP_W-1:0] best_hop;
  logic out_valid, out_new;
  logic [HOP_W-1:0] out_hop;

  int epoch = 0;
  int tests = 0, fails = 0, cycles = 0;
  bit m_seen [N];
  logic [TS_W-1:0]  m_ts  [N];
  logic [HOP_W-1:0] m_hop [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign best_hop = HOP_W'((best_dst * 3 + epoch) % (1 << HOP_W));

  flowlet_pin #(.IDX_W(IDX_W), .DST_W(DST_W), .HOP_W(HOP_W), .TS_W(TS_W)) dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_hash(pkt_hash),
    .pkt_dst(pkt_dst), .now(now), .gap_thresh(gap_thresh), .best_dst(best_dst),
    .best_hop(best_hop), .out_valid(out_valid), .out_new(out_new), .out_hop(out_hop)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // Called at a negedge; returns at the next negedge after checking the result.
  task automatic pkt(input int h, input int d, input int t, input string req);
    logic [TS_W-1:0] g;
    logic [HOP_W-1:0] bh, eh;
    bit en;
    pkt_valid = 1; pkt_hash = IDX_W'(h); pkt_dst = DST_W'(d); now = TS_W'(t);
    #1;
    check("R9 best_dst", best_dst, pkt_dst);
    bh = HOP_W'((d * 3 + epoch) % (1 << HOP_W));
    g  = TS_W'(now - m_ts[h]);
    en = !m_seen[h] || (g > gap_thresh);
    eh = en ? bh : m_hop[h];
    m_seen[h] = 1; m_ts[h] = now; m_hop[h] = eh;
    @(negedge clk);
    check("R1 out_valid", out_valid, 1);
    check({req, " out_new"}, out_new, en);
    check({req, " out_hop"}, out_hop, eh);
  endtask

  task automatic idle();
    pkt_valid = 0;
    @(negedge clk);
    check("R1 idle out_valid", out_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_seen[i] = 0; m_ts[i] = '0; m_hop[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset out_new", out_new, 0);

    // R5: first packet to each entry is new
    gap_thresh = 5;
    for (int h = 0; h < N; h++) pkt(h, h, 100, "R5");
    idle();

    // R6 / R2 / R3: gap sweep around threshold 5
    for (int g = 0; g < 11; g++) begin
      pkt(g, g + 1, 2000, "R6");
      epoch++;
      pkt(g, g + 1, 2000 + g, g > 5 ? "R2" : "R3");
      idle();
    end

    // R7: wrap of the time counter
    pkt(12, 3, 16'hFFFD, "R7");
    epoch++;
    pkt(12, 3, 16'h0001, "R7");
    pkt(13, 4, 16'hFFF0, "R7");
    epoch++;
    pkt(13, 4, 16'h0005, "R7");
    idle();

    // R4: steady stream with spacing == threshold stays pinned
    gap_thresh = 4;
    pkt(3, 9, 5000, "R4");
    for (int k = 1; k <= 10; k++) begin
      epoch++;
      pkt(3, 9, 5000 + 4 * k, "R4");
    end
    idle();

    // R8: back-to-back same entry
    pkt(7, 2, 9000, "R8");
    epoch++;
    pkt(7, 2, 9001, "R8");
    epoch++;
    pkt(7, 2, 9100, "R8");
    pkt(7, 2, 9100, "R8");
    idle();

    // R10 / R6 sweep: pseudo-random traffic under several thresholds
    begin
      logic [15:0] lfsr = 16'hACE1;
      int t = 20000;
      int thr [5] = '{0, 1, 7, 255, 65535};
      foreach (thr[j]) begin
        gap_thresh = TS_W'(thr[j]);
        for (int k = 0; k < 300; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          t += lfsr[2:0];
          if (lfsr[11:9] == 0) epoch++;
          if (lfsr[15]) idle();
          pkt(lfsr[7:4], lfsr[14:11], t, "R10");
        end
      end
    end
    idle();
    finish_run();
  end
endmodule